// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged 64-bit control registers of a processor core. They are addressed by an index, with one combinational read port and one write port that commits on the clock edge. Each index has its own write rule. Some registers keep the whole value. Some keep only the bits under a fixed mask. Some are cleared by any write. Some are set to a constant. Some exist only to issue a command to the instruction-side or data-side translation buffer, which sit outside this block.

Reads return the stored value, with two exceptions. The cycle-counter register joins its stored upper half with a free-running cycle count. The data-side page-table-entry register returns its fields in packed form, together with the current data-side address-space number.

Accesses that are not allowed raise a fault flag in the same cycle as the request: writes to read-only registers, reads of write-only registers, and any access to an index with no register behind it. A faulted access changes nothing.

Top module: `ctl_reg_bank`

## Requirements
- R1: Reset clears every register to zero and holds all command strobes low.
- R2: Full-width registers (scratch 0x00-0x07, cycle counter 0x1A, data PTE 0x2B) store all 64 write bits. A read returns data and fault combinationally in the request cycle, and a write is visible from the next cycle.
- R3: Masked writes keep only these bits. Trap enable 0x09 and trap request 0x0A keep 0xF. Priority level 0x0B keeps 0x1F. Instruction mode 0x0C, data mode 0x0D and alternate mode 0x0E keep 0x18. Soft interrupt 0x0F keeps 0x7FFF0. Instruction control 0x10 keeps 0xFF_FFFF_0300. Both page-table bases 0x11 and 0x12 keep 0xFFFF_FFFF_C000_0000. Cache test 0x13 keeps 0x1FFB. Both cache modes 0x14 and 0x15 keep 0x3F. Instruction ASN 0x16 keeps 0x7F0, with the ASN in bits [10:4]. Data ASN 0x17 keeps 0xFE00_0000_0000_0000, with the ASN in bits [63:57].
- R4: A write to the exception address 0x08 stores the data with bit 1 forced to zero.
- R5: Any write to exception summary 0x18 or exception mask 0x19 clears it to zero, whatever the data.
- R6: A read of 0x1A returns stored bits [63:32] above a 32-bit cycle count. The count is zero in the first cycle after reset release and rises by one every clock.
- R7: A write to counter control 0x1B stores the value 1, whatever the data.
- R8: Writes to the read-only indices 0x1C-0x20 raise wr_fault in the same cycle and leave the register unchanged. These registers read as zero.
- R9: Reads of the write-only indices 0x0E and 0x21-0x2A raise rd_fault and return zero. Indices 0x2D and above fault on both read and write.
- R10: A write to 0x25, 0x26, 0x27 or 0x28 raises one strobe for exactly the next cycle. The strobes are, in that order: cmd_d[0] (data flush all), cmd_d[1] (data flush non-global), cmd_i[0] (instruction flush all) and cmd_i[1] (instruction flush non-global).
- R11: A write to 0x29 pulses cmd_d[2], and a write to 0x2A pulses cmd_i[2]. During the pulse, cmd_addr carries the write data and cmd_asn carries the matching ASN field.
- R12: A read of 0x2B returns the stored value masked to 0x07FF_FFFF_0000_FF16, ORed with the data ASN placed at bit 57. The fields are PPN [58:32], read enable [11:8], write enable [15:12], fault-on-read bit 1, fault-on-write bit 2 and address-space match bit 4.
- R13: A write to tag 0x2C pulses cmd_d[3]. During the pulse, cmd_addr carries the tag, and the entry fields come from 0x2B and the data ASN; cmd_flg is {match, fault-on-write, fault-on-read}. If the granularity hint in bits [6:5] of 0x2B is nonzero, the write faults instead and no strobe follows.
- R14: At most one strobe is high in any cycle, and a strobe follows only a write that did not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDXW | Read index |
| rd_data | output | 64 | Read data, zero on fault |
| rd_fault | output | 1 | Read not allowed |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDXW | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write not allowed |
| cmd_d | output | 4 | Data-buffer strobes {insert, one, non-global, all} |
| cmd_i | output | 3 | Instruction-buffer strobes {one, non-global, all} |
| cmd_addr | output | 64 | Flush address or insert tag |
| cmd_asn | output | 7 | ASN carried with the command |
| cmd_ppn | output | 27 | Inserted page number |
| cmd_re | output | 4 | Inserted read enables |
| cmd_we | output | 4 | Inserted write enables |
| cmd_flg | output | 3 | Inserted {match, fault-on-write, fault-on-read} |

## Verification
A wrong decode or mask shows on the very next read of the index written, either as extra or missing bits or as a fault flag with the wrong value. Those reads are combinational, so the error appears in the same cycle as the read. A fault in the strobe logic appears one clock after the write, as a missing pulse, a wrong payload, a second pulse, or a pulse that lasts too long. A cycle count that drifts or stalls shows on any two reads of the counter, in the low half of the data.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [63:0]     rd_data,
  output logic            rd_fault,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [63:0]     wr_data,
  output logic            wr_fault,
  output logic [3:0]      cmd_d,
  output logic [2:0]      cmd_i,
  output logic [63:0]     cmd_addr,
  output logic [6:0]      cmd_asn,
  output logic [26:0]     cmd_ppn,
  output logic [3:0]      cmd_re,
  output logic [3:0]      cmd_we,
  output logic [2:0]      cmd_flg
);
  localparam int NREG = 2 ** IDXW;
  localparam int HALF = 32;
  localparam logic [63:0] PTE_VIS = 64'h07FF_FFFF_0000_FF16;

  localparam logic [IDXW-1:0] I_S7     = IDXW'('h07);
  localparam logic [IDXW-1:0] I_EXC    = IDXW'('h08);
  localparam logic [IDXW-1:0] I_TEN    = IDXW'('h09);
  localparam logic [IDXW-1:0] I_TREQ   = IDXW'('h0A);
  localparam logic [IDXW-1:0] I_IPL    = IDXW'('h0B);
  localparam logic [IDXW-1:0] I_IMODE  = IDXW'('h0C);
  localparam logic [IDXW-1:0] I_DMODE  = IDXW'('h0D);
  localparam logic [IDXW-1:0] I_ALT    = IDXW'('h0E);
  localparam logic [IDXW-1:0] I_SWI    = IDXW'('h0F);
  localparam logic [IDXW-1:0] I_ICTL   = IDXW'('h10);
  localparam logic [IDXW-1:0] I_IPTB   = IDXW'('h11);
  localparam logic [IDXW-1:0] I_DPTB   = IDXW'('h12);
  localparam logic [IDXW-1:0] I_CTEST  = IDXW'('h13);
  localparam logic [IDXW-1:0] I_CMODE0 = IDXW'('h14);
  localparam logic [IDXW-1:0] I_CMODE1 = IDXW'('h15);
  localparam logic [IDXW-1:0] I_IASN   = IDXW'('h16);
  localparam logic [IDXW-1:0] I_DASN   = IDXW'('h17);
  localparam logic [IDXW-1:0] I_ESUM   = IDXW'('h18);
  localparam logic [IDXW-1:0] I_EMASK  = IDXW'('h19);
  localparam logic [IDXW-1:0] I_CC     = IDXW'('h1A);
  localparam logic [IDXW-1:0] I_CCCTL  = IDXW'('h1B);
  localparam logic [IDXW-1:0] I_RO_LO  = IDXW'('h1C);
  localparam logic [IDXW-1:0] I_RO_HI  = IDXW'('h20);
  localparam logic [IDXW-1:0] I_WO_LO  = IDXW'('h21);
  localparam logic [IDXW-1:0] I_DALL   = IDXW'('h25);
  localparam logic [IDXW-1:0] I_DNG    = IDXW'('h26);
  localparam logic [IDXW-1:0] I_IALL   = IDXW'('h27);
  localparam logic [IDXW-1:0] I_ING    = IDXW'('h28);
  localparam logic [IDXW-1:0] I_DONE   = IDXW'('h29);
  localparam logic [IDXW-1:0] I_IONE   = IDXW'('h2A);
  localparam logic [IDXW-1:0] I_DPTE   = IDXW'('h2B);
  localparam logic [IDXW-1:0] I_DTAG   = IDXW'('h2C);

  function automatic logic [63:0] wmask(input logic [IDXW-1:0] i);
    case (i)
      I_EXC:                     return ~64'h2;
      I_TEN, I_TREQ:             return 64'hF;
      I_IPL:                     return 64'h1F;
      I_IMODE, I_DMODE, I_ALT:   return 64'h18;
      I_SWI:                     return 64'h7_FFF0;
      I_ICTL:                    return 64'hFF_FFFF_0300;
      I_IPTB, I_DPTB:            return 64'hFFFF_FFFF_C000_0000;
      I_CTEST:                   return 64'h1FFB;
      I_CMODE0, I_CMODE1:        return 64'h3F;
      I_IASN:                    return 64'h7F0;
      I_DASN:                    return 64'hFE00_0000_0000_0000;
      I_ESUM, I_EMASK:           return 64'h0;
      I_DALL, I_DNG, I_IALL, I_ING: return 64'h0;
      default:                   return '1;
    endcase
  endfunction

  function automatic logic can_read(input logic [IDXW-1:0] i);
    if (i == I_ALT) return 1'b0;
    if (i >= I_WO_LO && i <= I_IONE) return 1'b0;
    return i <= I_DPTE;
  endfunction

  function automatic logic can_write(input logic [IDXW-1:0] i);
    if (i >= I_RO_LO && i <= I_RO_HI) return 1'b0;
    return i <= I_DTAG;
  endfunction

  logic [63:0]     bank [NREG];
  logic [HALF-1:0] cnt;
  logic            wr_go;
  logic [63:0]     pte;

  assign pte      = bank[I_DPTE];
  assign wr_fault = wr_en && (!can_write(wr_idx) || (wr_idx == I_DTAG && pte[6:5] != 2'b00));
  assign wr_go    = wr_en && !wr_fault;
  assign rd_fault = rd_en && !can_read(rd_idx);

  always_comb begin
    rd_data = '0;
    if (rd_en && !rd_fault) begin
      if (rd_idx == I_CC)
        rd_data = {bank[I_CC][63:HALF], cnt};
      else if (rd_idx == I_DPTE)
        rd_data = (pte & PTE_VIS) | {bank[I_DASN][63:57], 57'b0};
      else
        rd_data = bank[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) bank[k] <= '0;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wr_go)
        bank[wr_idx] <= (wr_idx == I_CCCTL) ? 64'd1 : (wr_data & wmask(wr_idx));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_d    <= '0;
      cmd_i    <= '0;
      cmd_addr <= '0;
      cmd_asn  <= '0;
      cmd_ppn  <= '0;
      cmd_re   <= '0;
      cmd_we   <= '0;
      cmd_flg  <= '0;
    end else begin
      cmd_d <= '0;
      cmd_i <= '0;
      if (wr_go) begin
        case (wr_idx)
          I_DALL: cmd_d[0] <= 1'b1;
          I_DNG:  cmd_d[1] <= 1'b1;
          I_DONE: cmd_d[2] <= 1'b1;
          I_DTAG: cmd_d[3] <= 1'b1;
          I_IALL: cmd_i[0] <= 1'b1;
          I_ING:  cmd_i[1] <= 1'b1;
          I_IONE: cmd_i[2] <= 1'b1;
          default: ;
        endcase
        cmd_addr <= wr_data;
        cmd_asn  <= (wr_idx == I_IONE) ? bank[I_IASN][10:4] : bank[I_DASN][63:57];
        cmd_ppn  <= pte[58:32];
        cmd_re   <= pte[11:8];
        cmd_we   <= pte[15:12];
        cmd_flg  <= {pte[4], pte[2], pte[1]};
      end
    end
  end

  // R14
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_d, cmd_i}));

  // R14
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cmd_d, cmd_i}) |-> $past(wr_en && !wr_fault));

  // R13
  gh_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_DTAG && wr_fault) |=> !cmd_d[3]);

  // R9
  rd_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_data == '0);

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= I_RO_LO && wr_idx <= I_RO_HI) |-> wr_fault);

  // R4
  exc_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == I_EXC) |-> !rd_data[1]);

  // R6
  cc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == I_CC && $past(rst_n) && $past(rd_en && rd_idx == I_CC) && $stable(bank[I_CC]))
      |-> rd_data[HALF-1:0] == $past(rd_data[HALF-1:0]) + 1'b1);

  // R3
  ipl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == I_IPL) |-> rd_data[63:5] == '0);
endmodule

// File: tb/ctl_reg_bank_test.sv
`timescale 1ns/1ps
module ctl_reg_bank_test;
  logic        clk = 0, rst_n = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [5:0]  rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0, rd_data;
  logic        rd_fault, wr_fault;
  logic [3:0]  cmd_d;
  logic [2:0]  cmd_i;
  logic [63:0] cmd_addr;
  logic [6:0]  cmd_asn;
  logic [26:0] cmd_ppn;
  logic [3:0]  cmd_re, cmd_we;
  logic [2:0]  cmd_flg;
  int n_chk = 0, n_err = 0;
  logic [31:0] tb_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tb_cyc <= rst_n ? tb_cyc + 1 : 0;

  ctl_reg_bank uut (.clk, .rst_n, .rd_en, .rd_idx, .rd_data, .rd_fault,
    .wr_en, .wr_idx, .wr_data, .wr_fault, .cmd_d, .cmd_i, .cmd_addr,
    .cmd_asn, .cmd_ppn, .cmd_re, .cmd_we, .cmd_flg);

  typedef struct packed {
    logic [15:0] tag;
    logic [5:0]  idx;
    logic [63:0] wd;
    logic [63:0] ex;
  } vec_t;
  localparam logic [63:0] ONES = '1;
  localparam vec_t VT [19] = '{
    '{"R2", 6'h00, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    '{"R2", 6'h07, ONES, ONES},
    '{"R4", 6'h08, ONES, 64'hFFFF_FFFF_FFFF_FFFD},
    '{"R3", 6'h09, ONES, 64'hF},
    '{"R3", 6'h0A, ONES, 64'hF},
    '{"R3", 6'h0B, ONES, 64'h1F},
    '{"R3", 6'h0C, ONES, 64'h18},
    '{"R3", 6'h0D, ONES, 64'h18},
    '{"R3", 6'h0F, ONES, 64'h7_FFF0},
    '{"R3", 6'h10, ONES, 64'hFF_FFFF_0300},
    '{"R3", 6'h11, ONES, 64'hFFFF_FFFF_C000_0000},
    '{"R3", 6'h12, ONES, 64'hFFFF_FFFF_C000_0000},
    '{"R3", 6'h13, ONES, 64'h1FFB},
    '{"R3", 6'h14, ONES, 64'h3F},
    '{"R3", 6'h15, ONES, 64'h3F},
    '{"R3", 6'h16, ONES, 64'h7F0},
    '{"R3", 6'h17, ONES, 64'hFE00_0000_0000_0000},
    '{"R5", 6'h18, ONES, 64'h0},
    '{"R5", 6'h19, ONES, 64'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [63:0] d, output logic f);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_data = d;
    #1 f = wr_fault;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] i, output logic [63:0] d, output logic f);
    @(negedge clk);
    rd_en = 1; rd_idx = i;
    #1 d = rd_data; f = rd_fault;
    rd_en = 0;
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [63:0] d, d2;
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(6'h00, d, f); check("R1 scratch reset", d, 0);
    rd(6'h17, d, f); check("R1 asn reset", d, 0);
    check("R1 strobes reset", {cmd_d, cmd_i}, 0);

    for (int k = 0; k < 19; k++) begin
      wr(VT[k].idx, VT[k].wd, f);
      check({string'(VT[k].tag), " write fault"}, f, 0);
      rd(VT[k].idx, d, f);
      check({string'(VT[k].tag), " readback"}, d, VT[k].ex);
    end

    // R2 read reflects old value in write cycle, new one after
    wr(6'h03, 64'hA5A5, f);
    rd(6'h03, d, f); check("R2 visible next cycle", d, 64'hA5A5);

    // R6
    wr(6'h1A, 64'hAAAA_BBBB_1234_5678, f);
    rd(6'h1A, d, f); check("R6 counter join", d, {32'hAAAA_BBBB, tb_cyc});
    rd(6'h1A, d2, f); check("R6 counter step", d2[31:0], d[31:0] + 32'd1);

    // R7
    wr(6'h1B, 64'hDEAD_BEEF, f); check("R7 no fault", f, 0);
    rd(6'h1B, d, f); check("R7 stores one", d, 1);

    // R8
    wr(6'h1C, ONES, f); check("R8 write fault", f, 1);
    rd(6'h1C, d, f); check("R8 unchanged", d, 0); check("R8 readable", f, 0);
    wr(6'h20, 64'h55, f); check("R8 write fault hi", f, 1);
    rd(6'h20, d, f); check("R8 unchanged hi", d, 0);

    // R9
    wr(6'h22, 64'h77, f); check("R9 wo write ok", f, 0);
    rd(6'h22, d, f); check("R9 wo read fault", f, 1); check("R9 wo zero data", d, 0);
    rd(6'h0E, d, f); check("R9 alt mode read fault", f, 1);
    wr(6'h3F, 64'h1, f); check("R9 unknown write fault", f, 1);
    rd(6'h3F, d, f); check("R9 unknown read fault", f, 1);
    check("R14 no strobe after fault", {cmd_d, cmd_i}, 0);

    // R10
    wr(6'h25, ONES, f); check("R10 data flush all", {cmd_d, cmd_i}, 7'b0001_000);
    @(posedge clk); #1 check("R10 one cycle", {cmd_d, cmd_i}, 0);
    wr(6'h28, ONES, f); check("R10 instr flush non-global", {cmd_d, cmd_i}, 7'b0000_010);
    @(posedge clk); #1 check("R10 one cycle instr", {cmd_d, cmd_i}, 0);

    // R11
    wr(6'h17, {7'h2A, 57'b0}, f);
    wr(6'h29, 64'h1234_5000, f);
    check("R11 data one strobe", {cmd_d, cmd_i}, 7'b0100_000);
    check("R11 data addr", cmd_addr, 64'h1234_5000);
    check("R11 data asn", cmd_asn, 7'h2A);
    wr(6'h16, 64'h550, f);
    wr(6'h2A, 64'h9876_0000, f);
    check("R11 instr one strobe", {cmd_d, cmd_i}, 7'b0000_100);
    check("R11 instr asn", cmd_asn, 7'h55);

    // R12
    wr(6'h2B, (64'h5 << 32) | 64'hA00 | 64'h3000 | 64'h12 | (64'h1 << 20) | 64'h1, f);
    rd(6'h2B, d, f);
    check("R12 packed read", d, (64'h5 << 32) | 64'hA00 | 64'h3000 | 64'h12 | (64'h2A << 57));

    // R13
    wr(6'h2C, 64'hFEED_0000, f); check("R13 tag no fault", f, 0);
    check("R13 insert strobe", {cmd_d, cmd_i}, 7'b1000_000);
    check("R13 tag", cmd_addr, 64'hFEED_0000);
    check("R13 fields", {cmd_ppn, cmd_re, cmd_we, cmd_flg, cmd_asn},
          {27'h5, 4'hA, 4'h3, 3'b101, 7'h2A});
    wr(6'h2B, 64'h20, f);
    wr(6'h2C, 64'h1, f); check("R13 hint fault", f, 1);
    check("R13 no insert", {cmd_d, cmd_i}, 0);

    // R1 second reset
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(6'h09, d, f); check("R1 masked reg cleared", d, 0);
    rd(6'h1A, d, f); check("R1 counter restarts", d, {32'h0, tb_cyc});

    finish_up();
  end
endmodule